// File: doc/BRIEF.md
# Dual-Direction Mailbox Register Pair

This block carries single 36-bit messages between two independently clocked ports without going through a FIFO. Slot one is loaded from port A and consumed on port B. Slot two is loaded from port B and consumed on port A. Each slot has an active-low "full" indication, shown in both clock domains. The writer's view drops on the loading edge. The reader's view rises on the consuming edge. Each side learns of the other side's action through a toggle event that crosses the clock boundary in a two-stage synchronizer.

A port performs an access on its clock's rising edge when its select is LOW and its enable is HIGH. The mailbox select input steers the access to a slot. When mailbox select is LOW, the access belongs to the FIFO, which lies outside this block. Port B's read data shows slot one when mailbox select is HIGH and the FIFO word from outside when it is LOW.

Each slot has two small state machines, one per domain, each with states `SLOT_EMPTY` and `SLOT_FULL`:
- The writer machine takes LOAD (EMPTY to FULL) on an accepted write. It takes RELEASE (FULL to EMPTY) when the reader's clear toggle arrives.
- The reader machine takes ARRIVE (EMPTY to FULL) when the writer's set toggle arrives. It takes TAKE (FULL to EMPTY) on an accepted read.

A write to a slot that is still full is dropped, so an unread message is never overwritten.

Top module: `mailbox_pair`

## Requirements
- R1: While reset is asserted and after it is released, all four full flags are HIGH and both slot registers read as zero.
- R2: An access has effect only when the port's select is LOW and its enable is HIGH at the clock rising edge; otherwise flags and slot contents are unchanged.
- R3: A port-A access with a_wr HIGH and a_mbox HIGH, while slot one is empty, loads a_wdata into slot one and drives m1_full_n_a LOW on that clk_a edge.
- R4: Within three clk_b rising edges of a slot-one load, m1_full_n_b is LOW and b_rdata with b_mbox HIGH shows the loaded word.
- R5: A port-B access with b_rd HIGH and b_mbox HIGH, while m1_full_n_b is LOW, drives m1_full_n_b HIGH on that clk_b edge, and m1_full_n_a returns HIGH within three clk_a edges.
- R6: With b_mbox LOW, b_rdata equals b_fifo_data.
- R7: A port-B access with b_rd LOW and b_mbox HIGH, while slot two is empty, loads b_wdata into slot two and drives m2_full_n_b LOW on that edge. m2_full_n_a goes LOW within three clk_a edges, and a_rdata then shows the word.
- R8: A port-A access with a_wr LOW and a_mbox HIGH, while m2_full_n_a is LOW, drives m2_full_n_a HIGH on that edge, and m2_full_n_b returns HIGH within three clk_b edges.
- R9: A write to a slot whose writer-side flag is LOW is ignored: the slot's contents and flags are unchanged.
- R10: An access with mailbox select LOW leaves both slots and all flags unchanged.
- R11: A read of an empty slot leaves its flags HIGH and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_cs_n | input | 1 | Port A select, active LOW |
| a_en | input | 1 | Port A enable, active HIGH |
| a_wr | input | 1 | Port A direction: HIGH write, LOW read |
| a_mbox | input | 1 | Port A mailbox select |
| a_wdata | input | 36 | Port A write data |
| a_rdata | output | 36 | Slot two contents |
| b_cs_n | input | 1 | Port B select, active LOW |
| b_en | input | 1 | Port B enable, active HIGH |
| b_rd | input | 1 | Port B direction: HIGH read, LOW write |
| b_mbox | input | 1 | Port B mailbox select; also steers b_rdata |
| b_wdata | input | 36 | Port B write data |
| b_fifo_data | input | 36 | FIFO word from outside, shown when b_mbox is LOW |
| b_rdata | output | 36 | Port B read data |
| m1_full_n_a | output | 1 | Slot one full, clk_a view, active LOW |
| m1_full_n_b | output | 1 | Slot one full, clk_b view, active LOW |
| m2_full_n_a | output | 1 | Slot two full, clk_a view, active LOW |
| m2_full_n_b | output | 1 | Slot two full, clk_b view, active LOW |

## Verification
A writer or reader machine left in the wrong state shows up in one of three ways within a few destination clocks: the two views of a flag disagree after settling, a flag stays LOW forever, or a new message is wrongly refused or overwrites an unread one. A lost or doubled toggle leaves the two views of one flag permanently out of step, and that is visible at the next settled comparison. The bench drives one access at a time, waits for both domains to settle, and compares all four flags and both read buses with a reference model. Directed steps also check that the local flag changes on the access edge itself.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_t;
endpackage

// File: rtl/mbox_toggle_sync.sv
module mbox_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic tog_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], tog_in};
    end

    assign tog_out = chain_q[STAGES-1];
endmodule

// File: rtl/mbox_writer.sv
module mbox_writer
    import mbox_pkg::*;
#(
    parameter int WIDTH = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             clr_tog_sync,
    output logic [WIDTH-1:0] data_q,
    output logic             set_tog,
    output logic             full_n
);
    slot_state_t state_q, state_d;
    logic        seen_clr_q;
    logic        clr_event;
    logic        load;

    assign clr_event = clr_tog_sync ^ seen_clr_q;
    assign load      = (state_q == SLOT_EMPTY) && wr_req;

    // next-state: LOAD and RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (wr_req)    state_d = SLOT_FULL;
            SLOT_FULL:  if (clr_event) state_d = SLOT_EMPTY;
            default:                   state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= SLOT_EMPTY;
            seen_clr_q <= 1'b0;
            data_q     <= '0;
            set_tog    <= 1'b0;
        end else begin
            state_q    <= state_d;
            seen_clr_q <= clr_tog_sync;
            if (load) begin
                data_q  <= wr_data;
                set_tog <= ~set_tog;
            end
        end
    end

    always_comb begin
        full_n = (state_q == SLOT_EMPTY);
    end

    assert_flag_falls_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_n) |-> $past(wr_req));
    assert_full_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !full_n) |=> $stable(data_q));
    assert_idle_holds_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> $stable(data_q));
endmodule

// File: rtl/mbox_reader.sv
module mbox_reader
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic set_tog_sync,
    output logic clr_tog,
    output logic full_n
);
    slot_state_t state_q, state_d;
    logic        seen_set_q;
    logic        set_event;
    logic        take;

    assign set_event = set_tog_sync ^ seen_set_q;
    assign take      = (state_q == SLOT_FULL) && rd_req;

    // next-state: ARRIVE and TAKE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (set_event) state_d = SLOT_FULL;
            SLOT_FULL:  if (rd_req)    state_d = SLOT_EMPTY;
            default:                   state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= SLOT_EMPTY;
            seen_set_q <= 1'b0;
            clr_tog    <= 1'b0;
        end else begin
            state_q    <= state_d;
            seen_set_q <= set_tog_sync;
            if (take) clr_tog <= ~clr_tog;
        end
    end

    always_comb begin
        full_n = (state_q == SLOT_EMPTY);
    end

    assert_read_clears_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !full_n) |=> full_n);
    assert_flag_rises_only_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_n) |-> $past(rd_req));
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
    parameter int WIDTH  = 36,
    parameter int STAGES = 2
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    output logic [WIDTH-1:0] data,
    output logic             full_n_wr,
    output logic             full_n_rd
);
    logic set_tog, set_tog_rd;
    logic clr_tog, clr_tog_wr;

    mbox_writer #(.WIDTH(WIDTH)) u_writer (
        .clk          (wr_clk),
        .rst_n        (rst_n),
        .wr_req       (wr_req),
        .wr_data      (wr_data),
        .clr_tog_sync (clr_tog_wr),
        .data_q       (data),
        .set_tog      (set_tog),
        .full_n       (full_n_wr)
    );

    mbox_toggle_sync #(.STAGES(STAGES)) u_set_sync (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .tog_in  (set_tog),
        .tog_out (set_tog_rd)
    );

    mbox_reader u_reader (
        .clk          (rd_clk),
        .rst_n        (rst_n),
        .rd_req       (rd_req),
        .set_tog_sync (set_tog_rd),
        .clr_tog      (clr_tog),
        .full_n       (full_n_rd)
    );

    mbox_toggle_sync #(.STAGES(STAGES)) u_clr_sync (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .tog_in  (clr_tog),
        .tog_out (clr_tog_wr)
    );
endmodule

// File: rtl/mailbox_pair.sv
module mailbox_pair #(
    parameter int WIDTH  = 36,
    parameter int STAGES = 2
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             rst_n,
    input  logic             a_cs_n,
    input  logic             a_en,
    input  logic             a_wr,
    input  logic             a_mbox,
    input  logic [WIDTH-1:0] a_wdata,
    output logic [WIDTH-1:0] a_rdata,
    input  logic             b_cs_n,
    input  logic             b_en,
    input  logic             b_rd,
    input  logic             b_mbox,
    input  logic [WIDTH-1:0] b_wdata,
    input  logic [WIDTH-1:0] b_fifo_data,
    output logic [WIDTH-1:0] b_rdata,
    output logic             m1_full_n_a,
    output logic             m1_full_n_b,
    output logic             m2_full_n_a,
    output logic             m2_full_n_b
);
    logic             a_slot_acc, b_slot_acc;
    logic [WIDTH-1:0] slot1_data;

    assign a_slot_acc = !a_cs_n && a_en && a_mbox;
    assign b_slot_acc = !b_cs_n && b_en && b_mbox;

    // slot one: written on A, consumed on B
    mbox_channel #(.WIDTH(WIDTH), .STAGES(STAGES)) u_slot1 (
        .wr_clk    (clk_a),
        .rd_clk    (clk_b),
        .rst_n     (rst_n),
        .wr_req    (a_slot_acc && a_wr),
        .wr_data   (a_wdata),
        .rd_req    (b_slot_acc && b_rd),
        .data      (slot1_data),
        .full_n_wr (m1_full_n_a),
        .full_n_rd (m1_full_n_b)
    );

    // slot two: written on B, consumed on A
    mbox_channel #(.WIDTH(WIDTH), .STAGES(STAGES)) u_slot2 (
        .wr_clk    (clk_b),
        .rd_clk    (clk_a),
        .rst_n     (rst_n),
        .wr_req    (b_slot_acc && !b_rd),
        .wr_data   (b_wdata),
        .rd_req    (a_slot_acc && !a_wr),
        .data      (a_rdata),
        .full_n_wr (m2_full_n_b),
        .full_n_rd (m2_full_n_a)
    );

    assign b_rdata = b_mbox ? slot1_data : b_fifo_data;

    assert_deselect_keeps_m1_R10: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!a_mbox && m1_full_n_a) |=> !$fell(m1_full_n_a));
endmodule

// File: tb/mailbox_pair_test.sv
module mailbox_pair_test;
    localparam int W = 36;

    logic          clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    logic          a_cs_n = 1'b1, a_en = 1'b0, a_wr = 1'b0, a_mbox = 1'b0;
    logic [W-1:0]  a_wdata = '0, b_wdata = '0, b_fifo_data = '0;
    logic          b_cs_n = 1'b1, b_en = 1'b0, b_rd = 1'b0, b_mbox = 1'b0;
    logic [W-1:0]  a_rdata, b_rdata;
    logic          m1_full_n_a, m1_full_n_b, m2_full_n_a, m2_full_n_b;

    int n_checks = 0;
    int n_err    = 0;

    bit           full1 = 0, full2 = 0;
    logic [W-1:0] mail1 = '0, mail2 = '0;

    always #10 clk_a = ~clk_a;
    always #13 clk_b = ~clk_b;

    mailbox_pair uut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr), .a_mbox(a_mbox),
        .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_cs_n(b_cs_n), .b_en(b_en), .b_rd(b_rd), .b_mbox(b_mbox),
        .b_wdata(b_wdata), .b_fifo_data(b_fifo_data), .b_rdata(b_rdata),
        .m1_full_n_a(m1_full_n_a), .m1_full_n_b(m1_full_n_b),
        .m2_full_n_a(m2_full_n_a), .m2_full_n_b(m2_full_n_b)
    );

    function automatic logic [W-1:0] rnd_word();
        return {4'($urandom), 32'($urandom)};
    endfunction

    function automatic logic [W-1:0] exp_b_rdata(input bit mbox, input logic [W-1:0] fifo);
        return mbox ? mail1 : fifo;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic a_op(input bit cs_n, input bit en, input bit wr, input bit mbox,
                        input logic [W-1:0] d);
        @(negedge clk_a);
        a_cs_n = cs_n; a_en = en; a_wr = wr; a_mbox = mbox; a_wdata = d;
        @(negedge clk_a);
        a_cs_n = 1'b1; a_en = 1'b0; a_mbox = 1'b0;
        if (!cs_n && en && mbox) begin
            if (wr && !full1) begin full1 = 1; mail1 = d; end
            else if (!wr) full2 = 0;
        end
    endtask

    task automatic b_op(input bit cs_n, input bit en, input bit rd, input bit mbox,
                        input logic [W-1:0] d);
        @(negedge clk_b);
        b_cs_n = cs_n; b_en = en; b_rd = rd; b_mbox = mbox; b_wdata = d;
        @(negedge clk_b);
        b_cs_n = 1'b1; b_en = 1'b0;
        if (!cs_n && en && mbox) begin
            if (!rd && !full2) begin full2 = 1; mail2 = d; end
            else if (rd) full1 = 0;
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk_b);
        repeat (5) @(negedge clk_a);
    endtask

    task automatic check_all(input string req);
        logic [W-1:0] f;
        bit           m;
        f = rnd_word();
        m = 1'($urandom);
        b_fifo_data = f; b_mbox = m;
        #1;
        check({req, " m1_full_n_a"}, W'(m1_full_n_a), W'(!full1));
        check({req, " m1_full_n_b"}, W'(m1_full_n_b), W'(!full1));
        check({req, " m2_full_n_a"}, W'(m2_full_n_a), W'(!full2));
        check({req, " m2_full_n_b"}, W'(m2_full_n_b), W'(!full2));
        check({req, " a_rdata"}, a_rdata, mail2);
        check({req, " b_rdata"}, b_rdata, exp_b_rdata(m, f));
    endtask

    initial begin
        #4_000_000;
        n_checks++; n_err++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [W-1:0] d1, d2, d3;
        void'($urandom(32'd2024));
        #5;
        // R1: during reset
        check("R1 m1_full_n_a in reset", W'(m1_full_n_a), W'(1));
        check("R1 m2_full_n_b in reset", W'(m2_full_n_b), W'(1));
        #98 rst_n = 1'b1;
        settle();
        check_all("R1 after reset");

        // R2: deselected or disabled accesses do nothing
        a_op(1, 1, 1, 1, rnd_word());
        a_op(0, 0, 1, 1, rnd_word());
        b_op(1, 1, 0, 1, rnd_word());
        b_op(0, 0, 0, 1, rnd_word());
        settle();
        check_all("R2 unqualified");

        // R10: mailbox select low
        a_op(0, 1, 1, 0, rnd_word());
        b_op(0, 1, 0, 0, rnd_word());
        settle();
        check_all("R10 mbox low");

        // R3 / R4: slot one load and crossing
        d1 = rnd_word();
        a_op(0, 1, 1, 1, d1);
        check("R3 m1_full_n_a on edge", W'(m1_full_n_a), W'(0));
        repeat (4) @(negedge clk_b);
        b_mbox = 1'b1; #1;
        check("R4 m1_full_n_b", W'(m1_full_n_b), W'(0));
        check("R4 b_rdata", b_rdata, d1);

        // R9: write while full dropped
        d2 = rnd_word();
        a_op(0, 1, 1, 1, d2);
        settle();
        check_all("R9 full write");

        // R6: fifo path
        @(negedge clk_b);
        b_mbox = 1'b0; b_fifo_data = d2; #1;
        check("R6 fifo data", b_rdata, d2);

        // R5: slot one take
        b_op(0, 1, 1, 1, '0);
        check("R5 m1_full_n_b on edge", W'(m1_full_n_b), W'(1));
        repeat (4) @(negedge clk_a);
        check("R5 m1_full_n_a", W'(m1_full_n_a), W'(1));

        // R11: read of empty slots
        b_op(0, 1, 1, 1, '0);
        a_op(0, 1, 0, 1, '0);
        settle();
        check_all("R11 empty read");

        // R7: slot two load
        d3 = rnd_word();
        b_op(0, 1, 0, 1, d3);
        check("R7 m2_full_n_b on edge", W'(m2_full_n_b), W'(0));
        repeat (4) @(negedge clk_a);
        check("R7 m2_full_n_a", W'(m2_full_n_a), W'(0));
        check("R7 a_rdata", a_rdata, d3);

        // R8: slot two take
        a_op(0, 1, 0, 1, '0);
        check("R8 m2_full_n_a on edge", W'(m2_full_n_a), W'(1));
        repeat (4) @(negedge clk_b);
        check("R8 m2_full_n_b", W'(m2_full_n_b), W'(1));
        settle();
        check_all("R8 settled");

        // random mix covering R2 R3 R5 R6 R7 R8 R9 R10 R11
        for (int i = 0; i < 200; i++) begin
            bit cs_n, en, dir, mb;
            cs_n = ($urandom % 5) == 0;
            en   = ($urandom % 5) != 0;
            dir  = 1'($urandom);
            mb   = ($urandom % 4) != 0;
            if ($urandom % 2) a_op(cs_n, en, dir, mb, rnd_word());
            else              b_op(cs_n, en, dir, mb, rnd_word());
            settle();
            check_all("R3 R5 R7 R8 R9 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule